// File: doc/BRIEF.md
# Stack Pair Transfer Sequencer

This block moves one 16-bit register pair between a processor core and a byte-wide memory, using a 16-bit stack pointer that it owns. The core asks for one of three operations: push a pair, pop a pair, or store the stack pointer to an absolute address. It names the pair with a 2-bit code. The sequencer then runs the memory accesses one cycle at a time on a single-cycle synchronous byte port. It drives the address, write data, write enable and read enable, and it collects the returned bytes. When a pop finishes, it presents the assembled word together with the pair code for one cycle.

The pair holding the accumulator and the flags is treated specially. On a push, its low byte is the packed flag byte: zero at bit 7, subtract at bit 6, half-carry at bit 5, carry at bit 4, and bits 3:0 always zero. On a pop into that pair, the unused low nibble is cleared. The core can also load the stack pointer directly while the block is idle.

Top module: `stack_xfer`

## Requirements
- R1: After reset, `busy`, `memWe`, `memRe` and `popValid` are 0, and `sp` equals the parameter `SP_RESET` (default 0xFFFE).
- R2: A push (`reqOp` = 0) first writes the high byte of `reqWord` at SP-1 and then the low byte at SP-2. It leaves SP lowered by 2.
- R3: A pop (`reqOp` = 1) builds the word with the low byte read at SP and the high byte read at SP+1. It leaves SP raised by 2.
- R4: Pair codes are 0 = BC, 1 = DE, 2 = HL, 3 = AF. For AF, the high byte is the accumulator and the low byte is the flag byte. A push of AF writes that low byte with bits 3:0 forced to 0.
- R5: A pop into AF returns bits 3:0 of `popWord` as 0. A pop into any other pair returns the memory bytes unchanged.
- R6: A store-SP request (`reqOp` = 2) writes SP[7:0] at `reqAddr` and SP[15:8] at `reqAddr`+1. It leaves SP unchanged.
- R7: `busy` is high for exactly 4 cycles on a push, 3 on a pop and 2 on a store-SP. On a pop, `popValid` is high for exactly one cycle, the first cycle after `busy` falls, and `popPair` holds the requested pair code.
- R8: While `busy` is high, `reqValid` and `spSetValid` are ignored. `reqOp` = 3 is never accepted.
- R9: SP arithmetic and the store-SP address step wrap modulo 65536.
- R10: When the block is idle and no request is present, `spSetValid` loads `spSetValue` into SP on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqOp | input | 2 | 0 push, 1 pop, 2 store SP, 3 reserved |
| reqPair | input | 2 | Pair code (R4) |
| reqWord | input | 16 | Pair value for a push |
| reqAddr | input | 16 | Target address for store-SP |
| spSetValid | input | 1 | Direct SP load strobe |
| spSetValue | input | 16 | Value for the direct SP load |
| busy | output | 1 | Operation in progress |
| sp | output | 16 | Current stack pointer |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRe | output | 1 | Memory read enable; data is returned on the next cycle |
| memRdata | input | 8 | Memory read data |
| popValid | output | 1 | One-cycle pulse that marks a finished pop |
| popPair | output | 2 | Pair code of the finished pop |
| popWord | output | 16 | Popped word |

## Verification
A request is driven on a falling edge and taken at the next rising edge, and `busy` is high at the falling edge that follows. The bench counts falling edges until `busy` drops and expects 4, 3 or 2 by operation. On a pop, `popWord` and `popValid` are sampled at the first falling edge with `busy` low, and `popValid` is checked to be low again one edge later. Memory contents and `sp` are compared against a bench model only once `busy` has fallen, because the last write lands on the same edge that clears `busy`.

// File: rtl/stack_xfer_pkg.sv
package stack_xfer_pkg;

  localparam logic [1:0] OP_PUSH  = 2'd0;
  localparam logic [1:0] OP_POP   = 2'd1;
  localparam logic [1:0] OP_STORE = 2'd2;

  localparam logic [1:0] PAIR_AF = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PDEC1,
    S_PWHI,
    S_PDEC2,
    S_PWLO,
    S_RLO,
    S_RHI,
    S_RFIN,
    S_SLO,
    S_SHI
  } stateE;

  typedef struct packed {
    logic latch;
    logic spDec;
    logic spInc;
    logic spLoad;
    logic wrHi;
    logic wrLo;
    logic wrSpLo;
    logic wrSpHi;
    logic rdLo;
    logic rdHi;
    logic finPop;
  } strobeT;

endpackage

// File: rtl/stack_xfer_ctrl.sv
module stack_xfer_ctrl
  import stack_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       spSetValid,
  output strobeT     strobes,
  output logic       busy
);

  stateE stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobes = '0;
    stateD  = stateQ;
    unique case (stateQ)
      S_IDLE: begin
        if (reqValid && reqOp != 2'd3) begin
          strobes.latch = 1'b1;
          if (reqOp == OP_PUSH)     stateD = S_PDEC1;
          else if (reqOp == OP_POP) stateD = S_RLO;
          else                      stateD = S_SLO;
        end else if (spSetValid) begin
          strobes.spLoad = 1'b1;
        end
      end
      S_PDEC1: begin strobes.spDec  = 1'b1; stateD = S_PWHI;  end
      S_PWHI:  begin strobes.wrHi   = 1'b1; stateD = S_PDEC2; end
      S_PDEC2: begin strobes.spDec  = 1'b1; stateD = S_PWLO;  end
      S_PWLO:  begin strobes.wrLo   = 1'b1; stateD = S_IDLE;  end
      S_RLO:   begin strobes.rdLo   = 1'b1; strobes.spInc = 1'b1; stateD = S_RHI;  end
      S_RHI:   begin strobes.rdHi   = 1'b1; strobes.spInc = 1'b1; stateD = S_RFIN; end
      S_RFIN:  begin strobes.finPop = 1'b1; stateD = S_IDLE;  end
      S_SLO:   begin strobes.wrSpLo = 1'b1; stateD = S_SHI;   end
      S_SHI:   begin strobes.wrSpHi = 1'b1; stateD = S_IDLE;  end
      default: stateD = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);

  // R7: the final write of a push is followed by an idle cycle
  a_r7_push_ends: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_PWLO) |=> !busy);

  // R7: a store-SP takes exactly two busy cycles
  a_r7_store_len: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_SLO) |=> (stateQ == S_SHI));

  // R8: no request is latched while an operation runs
  a_r8_no_latch_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.latch && !strobes.spLoad);

endmodule

// File: rtl/stack_xfer_dp.sv
module stack_xfer_dp
  import stack_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'hFFFE
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobes,
  input  logic [1:0]          reqPair,
  input  logic [2*BYTE_W-1:0] reqWord,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [ADDR_W-1:0]   spSetValue,
  input  logic [BYTE_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   sp,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BYTE_W-1:0]   memWdata,
  output logic                memWe,
  output logic                memRe,
  output logic                popValid,
  output logic [1:0]          popPair,
  output logic [2*BYTE_W-1:0] popWord
);

  localparam int unsigned PAIR_W = 2 * BYTE_W;
  localparam int unsigned LOW_W  = BYTE_W / 2;
  localparam logic [BYTE_W-1:0] FLAG_KEEP = {{(BYTE_W-LOW_W){1'b1}}, {LOW_W{1'b0}}};
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] spQ, addrQ;
  logic [PAIR_W-1:0] pairQ, popWordQ;
  logic [1:0]        pairSelQ;
  logic [BYTE_W-1:0] loQ, pushLo, popLo;
  logic              popValidQ;

  assign pushLo = (pairSelQ == PAIR_AF) ? (pairQ[BYTE_W-1:0] & FLAG_KEEP) : pairQ[BYTE_W-1:0];
  assign popLo  = (pairSelQ == PAIR_AF) ? (loQ & FLAG_KEEP) : loQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ       <= SP_RESET;
      addrQ     <= '0;
      pairQ     <= '0;
      pairSelQ  <= '0;
      loQ       <= '0;
      popWordQ  <= '0;
      popValidQ <= 1'b0;
    end else begin
      popValidQ <= strobes.finPop;
      if (strobes.latch) begin
        pairQ    <= reqWord;
        pairSelQ <= reqPair;
        addrQ    <= reqAddr;
      end
      if (strobes.spLoad)     spQ <= spSetValue;
      else if (strobes.spDec) spQ <= spQ - ONE;
      else if (strobes.spInc) spQ <= spQ + ONE;
      if (strobes.rdHi)   loQ <= memRdata;
      if (strobes.finPop) popWordQ <= {memRdata, popLo};
    end
  end

  always_comb begin
    memAddr = spQ;
    if (strobes.wrSpLo)      memAddr = addrQ;
    else if (strobes.wrSpHi) memAddr = addrQ + ONE;
  end

  always_comb begin
    memWdata = '0;
    if (strobes.wrHi)        memWdata = pairQ[PAIR_W-1:BYTE_W];
    else if (strobes.wrLo)   memWdata = pushLo;
    else if (strobes.wrSpLo) memWdata = spQ[BYTE_W-1:0];
    else if (strobes.wrSpHi) memWdata = spQ[ADDR_W-1:ADDR_W-BYTE_W];
  end

  assign memWe    = strobes.wrHi | strobes.wrLo | strobes.wrSpLo | strobes.wrSpHi;
  assign memRe    = strobes.rdLo | strobes.rdHi;
  assign sp       = spQ;
  assign popValid = popValidQ;
  assign popPair  = pairSelQ;
  assign popWord  = popWordQ;

  // R2, R9: each decrement strobe lowers SP by one, wrapping
  a_r2_sp_dec: assert property (@(posedge clk) disable iff (!rstN)
    strobes.spDec && !strobes.spLoad |=> spQ == $past(spQ) - ONE);

  // R3, R9: each increment strobe raises SP by one, wrapping
  a_r3_sp_inc: assert property (@(posedge clk) disable iff (!rstN)
    strobes.spInc && !strobes.spDec && !strobes.spLoad |=> spQ == $past(spQ) + ONE);

  // R6: SP is untouched when no SP strobe is present
  a_r6_sp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.spDec && !strobes.spInc && !strobes.spLoad |=> $stable(spQ));

  // R5: a popped AF pair never carries a low flag nibble
  a_r5_af_mask: assert property (@(posedge clk) disable iff (!rstN)
    popValid && popPair == PAIR_AF |-> popWord[LOW_W-1:0] == '0);

  // R7: the pop completion marker lasts one cycle
  a_r7_pop_pulse: assert property (@(posedge clk) disable iff (!rstN)
    popValid |=> !popValid);

  // R8: the captured request stays put until the next acceptance
  a_r8_pair_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latch |=> $stable(pairQ) && $stable(addrQ));

  // R2: a write and a read never share a cycle
  a_r2_we_re_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

endmodule

// File: rtl/stack_xfer.sv
module stack_xfer
  import stack_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'hFFFE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqOp,
  input  logic [1:0]          reqPair,
  input  logic [2*BYTE_W-1:0] reqWord,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                spSetValid,
  input  logic [ADDR_W-1:0]   spSetValue,
  output logic                busy,
  output logic [ADDR_W-1:0]   sp,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BYTE_W-1:0]   memWdata,
  output logic                memWe,
  output logic                memRe,
  input  logic [BYTE_W-1:0]   memRdata,
  output logic                popValid,
  output logic [1:0]          popPair,
  output logic [2*BYTE_W-1:0] popWord
);

  strobeT strobes;

  stack_xfer_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .spSetValid (spSetValid),
    .strobes    (strobes),
    .busy       (busy)
  );

  stack_xfer_dp #(
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W),
    .SP_RESET (SP_RESET)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqPair    (reqPair),
    .reqWord    (reqWord),
    .reqAddr    (reqAddr),
    .spSetValue (spSetValue),
    .memRdata   (memRdata),
    .sp         (sp),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memWe      (memWe),
    .memRe      (memRe),
    .popValid   (popValid),
    .popPair    (popPair),
    .popWord    (popWord)
  );

endmodule

// File: tb/stack_xfer_tb_top.sv
module stack_xfer_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  pair;
    logic [15:0] word;
    logic [15:0] addr;
  } vecT;

  localparam int NVEC = 7;
  localparam vecT VECS [NVEC] = '{
    '{2'd0, 2'd0, 16'h1234, 16'h0000},
    '{2'd0, 2'd3, 16'hA5F7, 16'h0000},
    '{2'd1, 2'd2, 16'h0000, 16'h0000},
    '{2'd1, 2'd3, 16'h0000, 16'h0000},
    '{2'd2, 2'd0, 16'h0000, 16'hC000},
    '{2'd0, 2'd1, 16'hBEEF, 16'h0000},
    '{2'd1, 2'd3, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [1:0]  reqPair = 2'd0;
  logic [15:0] reqWord = '0;
  logic [15:0] reqAddr = '0;
  logic        spSetValid = 1'b0;
  logic [15:0] spSetValue = '0;
  logic        busy, memWe, memRe, popValid;
  logic [15:0] sp, memAddr, popWord;
  logic [7:0]  memWdata, memRdata;
  logic [1:0]  popPair;

  logic [7:0] mem [256];
  logic [7:0] model [256];
  logic [15:0] modelSp;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      memRdata <= 8'h00;
    end else begin
      if (memWe) mem[memAddr[7:0]] <= memWdata;
      if (memRe) memRdata <= mem[memAddr[7:0]];
    end
  end

  stack_xfer dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqPair(reqPair),
    .reqWord(reqWord), .reqAddr(reqAddr), .spSetValid(spSetValid), .spSetValue(spSetValue),
    .busy(busy), .sp(sp), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRe(memRe), .memRdata(memRdata), .popValid(popValid), .popPair(popPair), .popWord(popWord)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkMem(input string req);
    int bad = -1;
    for (int i = 0; i < 256; i++) if (mem[i] !== model[i] && bad < 0) bad = i;
    chk(bad < 0, req, (bad < 0) ? 32'h0 : {24'h0, mem[bad]}, (bad < 0) ? 32'h0 : {24'h0, model[bad]});
  endtask

  // Model of one operation; returns the expected popped word and busy length.
  task automatic modelOp(input vecT v, output logic [15:0] expWord, output int expCyc);
    logic [7:0] lo, hi;
    expWord = '0;
    expCyc = 0;
    case (v.op)
      2'd0: begin
        modelSp = modelSp - 16'd1; model[modelSp[7:0]] = v.word[15:8];
        modelSp = modelSp - 16'd1;
        model[modelSp[7:0]] = (v.pair == 2'd3) ? {v.word[7:4], 4'h0} : v.word[7:0];
        expCyc = 4;
      end
      2'd1: begin
        lo = model[modelSp[7:0]]; modelSp = modelSp + 16'd1;
        hi = model[modelSp[7:0]]; modelSp = modelSp + 16'd1;
        if (v.pair == 2'd3) lo[3:0] = 4'h0;
        expWord = {hi, lo};
        expCyc = 3;
      end
      default: begin
        model[v.addr[7:0]] = modelSp[7:0];
        model[v.addr[7:0] + 8'd1] = modelSp[15:8];
        expCyc = 2;
      end
    endcase
  endtask

  task automatic runOp(input vecT v, output int cyc);
    @(negedge clk);
    reqValid = 1'b1; reqOp = v.op; reqPair = v.pair; reqWord = v.word; reqAddr = v.addr;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (busy && cyc < 50) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic runChecked(input vecT v, input string tag);
    logic [15:0] expWord;
    int expCyc, cyc;
    modelOp(v, expWord, expCyc);
    runOp(v, cyc);
    chk(cyc == expCyc, {tag, " R7 busy length"}, cyc, expCyc);
    if (v.op == 2'd1) begin
      chk(popValid === 1'b1, {tag, " R7 popValid"}, popValid, 1);
      chk(popWord === expWord, {tag, (v.pair == 2'd3) ? " R5 popWord" : " R3 popWord"}, popWord, expWord);
      chk(popPair === v.pair, {tag, " R7 popPair"}, popPair, v.pair);
      @(negedge clk);
      chk(popValid === 1'b0, {tag, " R7 popValid pulse"}, popValid, 0);
    end
    chk(sp === modelSp, {tag, (v.op == 2'd2) ? " R6 sp" : " R2/R3 sp"}, sp, modelSp);
    chkMem({tag, (v.op == 2'd2) ? " R6 memory" : " R2 R4 memory"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    modelSp = 16'hFFFE;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy === 1'b0 && memWe === 1'b0 && memRe === 1'b0 && popValid === 1'b0,
        "R1 idle outputs", {busy, memWe, memRe, popValid}, 0);
    chk(sp === 16'hFFFE, "R1 sp reset", sp, 16'hFFFE);

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NVEC; k++) runChecked(VECS[k], $sformatf("vec%0d", k));

    // R8: reserved op is not accepted
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd3;
    @(negedge clk);
    reqValid = 1'b0; reqOp = 2'd0;
    chk(busy === 1'b0, "R8 reserved op ignored", busy, 0);
    chk(sp === modelSp, "R8 reserved op sp", sp, modelSp);

    // R8: requests and SP loads during a push are ignored
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; reqPair = 2'd2; reqWord = 16'h7788;
    modelSp = modelSp - 16'd1; model[modelSp[7:0]] = 8'h77;
    modelSp = modelSp - 16'd1; model[modelSp[7:0]] = 8'h88;
    @(negedge clk);
    reqOp = 2'd1; spSetValid = 1'b1; spSetValue = 16'h4321;
    cyc = 0;
    while (busy && cyc < 50) begin
      cyc++;
      if (cyc == 3) begin reqValid = 1'b0; spSetValid = 1'b0; end
      @(negedge clk);
    end
    chk(cyc == 4, "R8 busy length under extra requests", cyc, 4);
    chk(sp === modelSp, "R8 sp unaffected", sp, modelSp);
    chkMem("R8 memory");
    @(negedge clk);
    chk(busy === 1'b0 && popValid === 1'b0, "R8 no late accept", {busy, popValid}, 0);

    // R10: direct SP load while idle
    spSetValid = 1'b1; spSetValue = 16'h0000;
    @(negedge clk);
    spSetValid = 1'b0;
    modelSp = 16'h0000;
    chk(sp === 16'h0000, "R10 sp load", sp, 0);

    // R9: push wraps below zero
    runChecked('{2'd0, 2'd2, 16'h5A3C, 16'h0000}, "wrapPush R9");
    chk(sp === 16'hFFFE, "R9 push wrap sp", sp, 16'hFFFE);

    // R9: pop wraps above 0xFFFF
    spSetValid = 1'b1; spSetValue = 16'hFFFF;
    @(negedge clk);
    spSetValid = 1'b0;
    modelSp = 16'hFFFF;
    runChecked('{2'd1, 2'd0, 16'h0000, 16'h0000}, "wrapPop R9");
    chk(sp === 16'h0001, "R9 pop wrap sp", sp, 16'h0001);

    // R9 R6: store-SP at the top address wraps its second byte to zero
    runChecked('{2'd2, 2'd0, 16'h0000, 16'hFFFF}, "wrapStore R9");
    chk(mem[8'h00] === 8'h00 && mem[8'hFF] === 8'h01, "R9 store wrap bytes",
        {mem[8'hFF], mem[8'h00]}, 16'h0100);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule